// File: doc/BRIEF.md
# Trigger-Anchored Spatial Pattern Recorder

This block watches a stream of memory accesses and keeps a small table of the pages currently in use. The first access that lands in a page the table does not hold is the trigger: the block allocates an entry, stores the access's program-counter signature and the line the access touched, and asks the predictor for a pattern by pulsing a prediction-request bus. Later accesses to the same page mark their lines in a 16-bit footprint, one bit per cache line.

When a page leaves the table, the footprint is rotated right by the trigger line. Bit 0 of the result is then always the trigger line, and bit k means "line trigger+k (mod 16) was touched". The rotated footprint, with its signature and page tag, is sent out on the training bus for one cycle. A page leaves either because software or a neighbouring block retires it by address, or because a new page takes its slot. Slots are handed out in strict rotation, so the oldest allocation is replaced first. Two footprints that are shifted copies of each other therefore train the same pattern.

Top module: `spat_rec`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `pred_vld` and `upd_vld` are low and the table holds no page.
- R2: An access (`acc_vld` high, `evict_vld` low) to a page the table does not hold raises `pred_vld` for one cycle, one cycle later, carrying `pred_sig` = `acc_sig`, `pred_off` = the access's line index and `pred_tag` = its page tag.
- R3: The line index is address bits [9:6] (64-byte lines, 16 lines per page) and the page tag is address bits [31:10]. An access to a page already held sets that page's bit for the line and raises no `pred_vld`.
- R4: An access to a line whose bit is already set leaves the page's footprint unchanged.
- R5: `evict_vld` with `evict_addr` in a held page raises `upd_vld` for one cycle, one cycle later, with `upd_tag` = the page tag and `upd_pat[i]` = footprint bit (i + trigger line) mod 16. The entry is freed, so the next access to that page is a new trigger.
- R6: `evict_vld` for a page the table does not hold raises no `upd_vld`.
- R7: New pages take slots 0,1,...,7 in turn and then wrap. If the slot taken still holds a page, that page's rotated footprint goes out on the training bus in the same cycle as the new page's `pred_vld`.
- R8: When `evict_vld` and `acc_vld` are both high, the eviction is handled and the access is ignored.
- R9: Every `upd_pat` emitted has bit 0 set, because the trigger line is recorded.
- R10: `upd_sig` is the signature of the trigger access. Later accesses to the page do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_vld | input | 1 | Access valid |
| acc_addr | input | 32 | Access byte address |
| acc_sig | input | 12 | Program-counter signature of the access |
| evict_vld | input | 1 | Retire the page containing `evict_addr` |
| evict_addr | input | 32 | Address in the page to retire |
| pred_vld | output | 1 | Prediction request pulse for a trigger access |
| pred_sig | output | 12 | Trigger signature |
| pred_off | output | 4 | Trigger line index |
| pred_tag | output | 22 | Trigger page tag |
| upd_vld | output | 1 | Training update pulse |
| upd_sig | output | 12 | Signature of the retired page |
| upd_tag | output | 22 | Tag of the retired page |
| upd_pat | output | 16 | Footprint rotated to the trigger line |

## Verification
Both result buses are registered. A prediction request or training update caused by the inputs sampled at one rising edge appears right after that edge and lasts one cycle, and table changes affect the next accepted input. The bench therefore drives inputs on the falling edge and compares both buses 1 ns after the following rising edge against its own table model. At every step it also checks that neither pulse appears when none is due. Reset release passes a two-stage synchronizer, so the bench waits several cycles before the first access.

// File: rtl/spat_rec_pkg.sv
package spat_rec_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_TOUCH  = 2'd1,
    OP_ALLOC  = 2'd2,
    OP_RETIRE = 2'd3
  } rec_op_e;
endpackage

// File: rtl/spat_rec_lookup.sv
module spat_rec_lookup #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 22,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [TAG_W-1:0]   tags [ENTRIES],
  input  logic [TAG_W-1:0]   key,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/spat_rec_rotate.sv
module spat_rec_rotate #(
  parameter int W      = 16,
  localparam int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stg [AMT_W+1];

  assign stg[0] = din;
  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][K-1:0], stg[s][W-1:K]} : stg[s];
  end
  assign dout = stg[AMT_W];
endmodule

// File: rtl/spat_rec.sv
module spat_rec #(
  parameter int ADDR_W     = 32,
  parameter int SIG_W      = 12,
  parameter int ENTRIES    = 8,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 64,
  localparam int LINE_W    = $clog2(LINES),
  localparam int BOFF_W    = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - LINE_W - BOFF_W,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIG_W-1:0]  acc_sig,
  input  logic              evict_vld,
  input  logic [ADDR_W-1:0] evict_addr,
  output logic              pred_vld,
  output logic [SIG_W-1:0]  pred_sig,
  output logic [LINE_W-1:0] pred_off,
  output logic [TAG_W-1:0]  pred_tag,
  output logic              upd_vld,
  output logic [SIG_W-1:0]  upd_sig,
  output logic [TAG_W-1:0]  upd_tag,
  output logic [LINES-1:0]  upd_pat
);
  import spat_rec_pkg::*;

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  // page table
  logic [ENTRIES-1:0] ent_vld;
  logic [TAG_W-1:0]   ent_tag [ENTRIES];
  logic [LINE_W-1:0]  ent_off [ENTRIES];
  logic [SIG_W-1:0]   ent_sig [ENTRIES];
  logic [LINES-1:0]   ent_pat [ENTRIES];
  logic [IDX_W-1:0]   wr_ptr;

  logic [TAG_W-1:0]  acc_tag, ev_tag;
  logic [LINE_W-1:0] acc_line;
  assign acc_tag  = acc_addr[ADDR_W-1 -: TAG_W];
  assign ev_tag   = evict_addr[ADDR_W-1 -: TAG_W];
  assign acc_line = acc_addr[BOFF_W +: LINE_W];

  logic [ENTRIES-1:0] hit_vec, ev_hit_vec;
  logic               acc_hit, ev_hit;
  logic [IDX_W-1:0]   acc_idx, ev_idx;

  spat_rec_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_acc_lkp (
    .vld(ent_vld), .tags(ent_tag), .key(acc_tag),
    .hit_vec(hit_vec), .hit(acc_hit), .idx(acc_idx)
  );

  spat_rec_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_ev_lkp (
    .vld(ent_vld), .tags(ent_tag), .key(ev_tag),
    .hit_vec(ev_hit_vec), .hit(ev_hit), .idx(ev_idx)
  );

  // operation decode: eviction wins over access
  rec_op_e op;
  always_comb begin
    if (evict_vld)    op = ev_hit  ? OP_RETIRE : OP_IDLE;
    else if (acc_vld) op = acc_hit ? OP_TOUCH  : OP_ALLOC;
    else              op = OP_IDLE;
  end

  // victim selection and anchoring
  logic [IDX_W-1:0] vic_idx;
  logic             emit;
  logic [LINES-1:0] vic_rot;
  assign vic_idx = (op == OP_RETIRE) ? ev_idx : wr_ptr;
  assign emit    = (op == OP_RETIRE) || ((op == OP_ALLOC) && ent_vld[wr_ptr]);

  spat_rec_rotate #(.W(LINES)) u_rot (
    .din(ent_pat[vic_idx]), .amt(ent_off[vic_idx]), .dout(vic_rot)
  );

  // next-state for the single table write per cycle
  logic              wr_en, nxt_vld;
  logic [IDX_W-1:0]  wr_idx;
  logic [LINES-1:0]  nxt_pat;
  logic [LINES-1:0]  line_bit;
  assign line_bit = LINES'(1) << acc_line;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = wr_ptr;
    nxt_vld = 1'b1;
    nxt_pat = line_bit;
    unique case (op)
      OP_RETIRE: begin
        wr_en   = 1'b1;
        wr_idx  = ev_idx;
        nxt_vld = 1'b0;
        nxt_pat = ent_pat[ev_idx];
      end
      OP_TOUCH: begin
        wr_en   = 1'b1;
        wr_idx  = acc_idx;
        nxt_pat = ent_pat[acc_idx] | line_bit;
      end
      OP_ALLOC: wr_en = 1'b1;
      default:  wr_en = 1'b0;
    endcase
  end

  logic alloc_en;
  assign alloc_en = (op == OP_ALLOC);

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ent_vld <= '0;
      wr_ptr  <= '0;
    end else begin
      if (wr_en) ent_vld[wr_idx] <= nxt_vld;
      if (alloc_en)
        wr_ptr <= (wr_ptr == IDX_W'(ENTRIES-1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) ent_pat[i] <= nxt_pat;
      if (alloc_en && (wr_ptr == IDX_W'(i))) begin
        ent_tag[i] <= acc_tag;
        ent_off[i] <= acc_line;
        ent_sig[i] <= acc_sig;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pred_vld <= 1'b0;
      pred_sig <= '0;
      pred_off <= '0;
      pred_tag <= '0;
      upd_vld  <= 1'b0;
      upd_sig  <= '0;
      upd_tag  <= '0;
      upd_pat  <= '0;
    end else begin
      pred_vld <= alloc_en;
      if (alloc_en) begin
        pred_sig <= acc_sig;
        pred_off <= acc_line;
        pred_tag <= acc_tag;
      end
      upd_vld <= emit;
      if (emit) begin
        upd_sig <= ent_sig[vic_idx];
        upd_tag <= ent_tag[vic_idx];
        upd_pat <= vic_rot;
      end
    end
  end
endmodule

// File: rtl/spat_rec_chk.sv
module spat_rec_chk #(
  parameter int ENTRIES = 8,
  parameter int LINES   = 16
) (
  input logic               clk,
  input logic               rst_q,
  input logic               acc_vld,
  input logic               evict_vld,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               pred_vld,
  input logic               upd_vld,
  input logic [LINES-1:0]   upd_pat
);
  // R3
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(hit_vec));

  // R2
  pred_src_chk: assert property (@(posedge clk) disable iff (!rst_q)
    pred_vld |-> ($past(acc_vld) && !$past(evict_vld) && !$past(|hit_vec)));

  // R5
  upd_src_chk: assert property (@(posedge clk) disable iff (!rst_q)
    upd_vld |-> ($past(evict_vld) || $past(acc_vld)));

  // R9
  anchor_bit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    upd_vld |-> upd_pat[0]);

  // R8
  evict_wins_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_vld && evict_vld) |=> !pred_vld);
endmodule

bind spat_rec spat_rec_chk #(.ENTRIES(ENTRIES), .LINES(LINES)) u_chk (
  .clk(clk), .rst_q(rst_q), .acc_vld(acc_vld), .evict_vld(evict_vld),
  .hit_vec(hit_vec), .pred_vld(pred_vld), .upd_vld(upd_vld), .upd_pat(upd_pat)
);

// File: tb/spat_rec_test.sv
module spat_rec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0, evict_vld = 1'b0;
  logic [31:0] acc_addr = '0, evict_addr = '0;
  logic [11:0] acc_sig = '0;
  logic        pred_vld, upd_vld;
  logic [11:0] pred_sig, upd_sig;
  logic [3:0]  pred_off;
  logic [21:0] pred_tag, upd_tag;
  logic [15:0] upd_pat;

  always #2 clk = ~clk;

  spat_rec uut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .acc_sig(acc_sig), .evict_vld(evict_vld), .evict_addr(evict_addr),
    .pred_vld(pred_vld), .pred_sig(pred_sig), .pred_off(pred_off),
    .pred_tag(pred_tag), .upd_vld(upd_vld), .upd_sig(upd_sig),
    .upd_tag(upd_tag), .upd_pat(upd_pat)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string rq, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference table
  bit        m_vld [8];
  bit [21:0] m_tag [8];
  bit [3:0]  m_off [8];
  bit [11:0] m_sig [8];
  bit [15:0] m_pat [8];
  int        m_ptr = 0;

  function automatic bit [15:0] rotr(bit [15:0] p, bit [3:0] off);
    bit [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = p[(i + off) % 16];
    return r;
  endfunction

  function automatic bit [31:0] mk(bit [21:0] tag, bit [3:0] line);
    return {tag, line, 6'($urandom_range(0, 63))};
  endfunction

  function automatic int find(bit [21:0] tag);
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_tag[i] == tag) return i;
    return -1;
  endfunction

  task automatic step(bit a, bit [31:0] aa, bit [11:0] as, bit e, bit [31:0] ea,
                      string rq_p, string rq_u);
    bit e_pv = 0, e_uv = 0;
    bit [11:0] e_ps = 0, e_us = 0;
    bit [3:0]  e_po = 0;
    bit [21:0] e_pt = 0, e_ut = 0;
    bit [15:0] e_up = 0;
    int k;
    @(negedge clk);
    acc_vld = a; acc_addr = aa; acc_sig = as;
    evict_vld = e; evict_addr = ea;
    if (e) begin
      k = find(ea[31:10]);
      if (k >= 0) begin
        e_uv = 1; e_us = m_sig[k]; e_ut = m_tag[k];
        e_up = rotr(m_pat[k], m_off[k]); m_vld[k] = 0;
      end
    end else if (a) begin
      k = find(aa[31:10]);
      if (k >= 0) m_pat[k] = m_pat[k] | (16'd1 << aa[9:6]);
      else begin
        if (m_vld[m_ptr]) begin
          e_uv = 1; e_us = m_sig[m_ptr]; e_ut = m_tag[m_ptr];
          e_up = rotr(m_pat[m_ptr], m_off[m_ptr]);
        end
        m_vld[m_ptr] = 1; m_tag[m_ptr] = aa[31:10]; m_off[m_ptr] = aa[9:6];
        m_sig[m_ptr] = as; m_pat[m_ptr] = 16'd1 << aa[9:6];
        e_pv = 1; e_ps = as; e_po = aa[9:6]; e_pt = aa[31:10];
        m_ptr = (m_ptr + 1) % 8;
      end
    end
    @(posedge clk); #1;
    chk(rq_p, "pred_vld", pred_vld, e_pv);
    if (e_pv && pred_vld) begin
      chk(rq_p, "pred_sig", pred_sig, e_ps);
      chk(rq_p, "pred_off", pred_off, e_po);
      chk(rq_p, "pred_tag", pred_tag, e_pt);
    end
    chk(rq_u, "upd_vld", upd_vld, e_uv);
    if (e_uv && upd_vld) begin
      chk("R10", "upd_sig", upd_sig, e_us);
      chk(rq_u, "upd_tag", upd_tag, e_ut);
      chk(rq_u, "upd_pat", upd_pat, e_up);
      chk("R9", "upd_pat[0]", upd_pat[0], 1);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pred_vld in reset", pred_vld, 0);
    chk("R1", "upd_vld in reset", upd_vld, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "pred_vld after reset", pred_vld, 0);
    chk("R1", "upd_vld after reset", upd_vld, 0);

    // R2 trigger, R3 touches, R4 repeat, R10 sig kept
    step(1, mk(22'h5, 4'd3), 12'h111, 0, 0, "R2", "R5");
    step(1, mk(22'h5, 4'd7), 12'h222, 0, 0, "R3", "R5");
    step(1, mk(22'h5, 4'd3), 12'h333, 0, 0, "R4", "R5");
    step(1, mk(22'h5, 4'd0), 12'h444, 0, 0, "R3", "R5");
    step(0, 0, 0, 1, mk(22'h5, 4'd9), "R5", "R5");
    // lines 0,3,7 anchored at 3 -> bits 13,0,4
    chk("R5", "directed upd_pat", upd_pat, 16'h2011);
    step(0, 0, 0, 1, mk(22'h5, 4'd1), "R6", "R6");
    // R5 freed entry retriggers
    step(1, mk(22'h5, 4'd15), 12'h555, 0, 0, "R5", "R5");
    step(0, 0, 0, 1, mk(22'h5, 4'd0), "R5", "R5");
    chk("R5", "single line at 15 anchored", upd_pat, 16'h0001);
    // R8 simultaneous: access dropped
    step(1, mk(22'h77, 4'd2), 12'h666, 1, mk(22'h99, 4'd0), "R8", "R6");
    step(1, mk(22'h77, 4'd4), 12'h666, 0, 0, "R8", "R5");
    // R7 fill and wrap
    for (int i = 0; i < 10; i++)
      step(1, mk(22'h100 + 22'(i), 4'(i)), 12'(i * 7 + 1), 0, 0, "R7", "R7");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit [21:0] t = 22'h200 + 22'($urandom_range(0, 11));
      int r = $urandom_range(0, 99);
      if (r < 12)      step(0, 0, 0, 1, mk(t, 4'($urandom)), "R8", "R5");
      else if (r < 16) step(1, mk(t, 4'($urandom)), 12'($urandom), 1,
                            mk(22'h200 + 22'($urandom_range(0, 11)), 4'd0), "R8", "R5");
      else if (r < 22) step(0, 0, 0, 0, 0, "R2", "R5");
      else             step(1, mk(t, 4'($urandom)), 12'($urandom), 0, 0, "R2", "R7");
    end
    finish_run();
  end
endmodule